// File: doc/BRIEF.md
# IDE Task-File Hidden Configuration Unlock

This block sits beside an IDE task-file decoder and watches the host's I/O accesses. It holds the sector-count register and the sector-number register itself. It also holds a hidden speed register that sets the transfer timing of the two attached devices. The speed register cannot be reached until the host performs a fixed order of ordinary task-file accesses. When that order completes, the block enters a programming mode. In this mode, the sector-number address reaches the speed register. A read of the close port leaves programming mode again.

One access is taken per rising edge of a read or write strobe. The address and the write data are sampled on that same edge. The effective per-device speed codes and the bus-clock range flag are driven from registers so that a timing generator can use them directly. A jumper value sets the device 1 speed at reset.

Top module: `ide_unlock_ctrl`

## Requirements
- R1: An access is taken only on the first clock edge at which a strobe is seen high. A strobe held high over several edges counts as one access. Read and write strobes never rise together.
- R2: Programming mode opens when the detector sees this exact order of accesses: a write to 0x1F2 with data bit 7 = 1, a read of 0x1F5, then reads of 0x1F2, 0x3F6, 0x3F6, 0x1F2 and 0x1F2. The `prog_mode` output goes high on the edge that samples the last read.
- R3: On the edge that completes the order, bit 7 of the sector-count register is cleared. The completing read still returns bit 7 as written. When the order is not completed, bit 7 keeps its written value.
- R4: Once the detector has left idle, any access that is not the next expected one returns it to idle. If that access is itself a write to 0x1F2 with bit 7 = 1, the detector counts it as a new first step.
- R5: Every read of 0x1F5 clears `prog_mode` and returns 0x00.
- R6: While programming mode is open, 0x1F3 reads and writes the 8-bit speed register. Bits 5:3 hold the device 0 code and bits 2:0 hold the device 1 code. Bit 6 = 1 marks a bus clock of 33 MHz or below, and bit 7 is stored. The register is visible on `speed_cfg`.
- R7: While programming mode is closed, 0x1F3 reads and writes an ordinary sector-number register, and the speed register does not change.
- R8: A read of 0x1F2 returns the last written sector-count value with bit 3 forced to 1, and with bit 7 cleared if R3 applied.
- R9: While sector-count bit 6 is 1, both `dev0_speed` and `dev1_speed` are 7. Otherwise they follow speed register bits 5:3 and 2:0.
- R10: Reset (synchronous, active high) clears prog_mode, read data, the detector, the sector-count and the sector-number registers. It loads the speed register with {5'b0, jumper[2:1], 1'b0}, so the device 1 code is 0, 2, 4 or 6.
- R11: A read of any address other than 0x1F2 and 0x1F3 returns 0x00. `io_rdata` changes only on a read access and holds its value otherwise.
- R12: `dev0_speed`, `dev1_speed` and `slow_bus` are registered. They show the register state one clock after it changes. `slow_bus` equals speed register bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | Decoded host I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| jumper | input | 3 | Jumper speed code for device 1 at reset |
| io_rdata | output | 8 | Registered read data of the last read access |
| prog_mode | output | 1 | Programming mode open |
| speed_cfg | output | 8 | Stored speed register |
| dev0_speed | output | 3 | Effective device 0 speed code |
| dev1_speed | output | 3 | Effective device 1 speed code |
| slow_bus | output | 1 | Bus clock at or below 33 MHz |

## Verification
The detector is driven in four ways:
- The exact unlock order, which shows that the mode opens and that bit 7 clears.
- The order broken after its third step, which must leave the mode closed and bit 7 set.
- The order restarted by a second bit-7 write in the middle, which separates a restart from a plain return to idle.
- The order with one strobe held over three clocks, which separates per-edge sampling from per-pulse sampling.

Random mixes of reads and writes over the owned and unowned ports follow, with full unlock orders inserted among them. They are compared after every access against a bench model of the registers and the detector. Resets with two jumper values check the reset load of the speed register.

// File: rtl/ide_unlock_pkg.sv
package ide_unlock_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int SPD_W  = 3;

  localparam logic [ADDR_W-1:0] PORT_SECCNT = 10'h1F2;
  localparam logic [ADDR_W-1:0] PORT_SECNUM = 10'h1F3;
  localparam logic [ADDR_W-1:0] PORT_CLOSE  = 10'h1F5;
  localparam logic [ADDR_W-1:0] PORT_ALTST  = 10'h3F6;

  localparam logic [DATA_W-1:0] SECCNT_FIXED = 8'h08;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_RD1   = 3'd2,
    ST_RD2   = 3'd3,
    ST_RD3   = 3'd4,
    ST_RD4   = 3'd5,
    ST_RD5   = 3'd6
  } seq_st_e;
endpackage

// File: rtl/io_access_sampler.sv
module io_access_sampler
  import ide_unlock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic io_rd,
  input  logic io_wr,
  output logic acc_rd,
  output logic acc_wr
);
  logic rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= io_rd;
      wr_q <= io_wr;
    end
  end

  assign acc_rd = io_rd & ~rd_q;
  assign acc_wr = io_wr & ~wr_q;

  AST_ONE_READ_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> !acc_rd); // R1
  AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> !acc_wr); // R1
endmodule

// File: rtl/unlock_seq_fsm.sv
module unlock_seq_fsm
  import ide_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_d7,
  output logic              prog_mode,
  output logic              seq_done
);
  seq_st_e st_q, st_d;
  logic    step_ok, start_hit, close_hit, any_acc;

  assign any_acc   = acc_rd | acc_wr;
  assign start_hit = acc_wr & (acc_addr == PORT_SECCNT) & acc_d7;
  assign close_hit = acc_rd & (acc_addr == PORT_CLOSE);

  always_comb begin
    unique case (st_q)
      ST_IDLE:  step_ok = start_hit;
      ST_ARMED: step_ok = close_hit;
      ST_RD1,
      ST_RD4,
      ST_RD5:   step_ok = acc_rd & (acc_addr == PORT_SECCNT);
      ST_RD2,
      ST_RD3:   step_ok = acc_rd & (acc_addr == PORT_ALTST);
      default:  step_ok = 1'b0;
    endcase
  end

  assign seq_done = step_ok & (st_q == ST_RD5);

  always_comb begin
    st_d = st_q;
    if (any_acc) begin
      if (seq_done)      st_d = ST_IDLE;
      else if (step_ok)  st_d = seq_st_e'(st_q + 3'd1);
      else if (start_hit) st_d = ST_ARMED;
      else               st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      prog_mode <= 1'b0;
    end else begin
      st_q <= st_d;
      if (close_hit)     prog_mode <= 1'b0;
      else if (seq_done) prog_mode <= 1'b1;
    end
  end

  AST_OPEN_ONLY_BY_SEQ: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_mode) |-> $past(seq_done)); // R2
  AST_OPEN_AFTER_SEQ: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> prog_mode); // R2
  AST_CLOSE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    close_hit |=> !prog_mode); // R5
  AST_BREAK_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (any_acc && !step_ok && !start_hit) |=> (st_q == ST_IDLE)); // R4
endmodule

// File: rtl/timing_cfg_regs.sv
module timing_cfg_regs
  import ide_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              prog_mode,
  input  logic              seq_done,
  input  logic [SPD_W-1:0]  jumper,
  output logic [DATA_W-1:0] rdata_q,
  output logic [DATA_W-1:0] speed_q,
  output logic [SPD_W-1:0]  dev0_q,
  output logic [SPD_W-1:0]  dev1_q,
  output logic              slow_q
);
  localparam logic [SPD_W-1:0] SPD_MAX  = {SPD_W{1'b1}};
  localparam int               D0_LO    = SPD_W;
  localparam int               SLOW_BIT = 2 * SPD_W;
  localparam int               FORCE_BIT = 6;

  logic [DATA_W-1:0] seccnt_q, secnum_q, rd_mux;
  logic [SPD_W-1:0]  jumper_even;

  assign jumper_even = jumper & {{(SPD_W-1){1'b1}}, 1'b0};

  always_comb begin
    if (acc_addr == PORT_SECCNT)      rd_mux = seccnt_q | SECCNT_FIXED;
    else if (acc_addr == PORT_SECNUM) rd_mux = prog_mode ? speed_q : secnum_q;
    else                              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seccnt_q <= '0;
      secnum_q <= '0;
      speed_q  <= {{(DATA_W-SPD_W){1'b0}}, jumper_even};
      rdata_q  <= '0;
      dev0_q   <= '0;
      dev1_q   <= '0;
      slow_q   <= 1'b0;
    end else begin
      if (acc_rd) rdata_q <= rd_mux;
      if (seq_done) seccnt_q[DATA_W-1] <= 1'b0;
      if (acc_wr) begin
        if (acc_addr == PORT_SECCNT) seccnt_q <= acc_data;
        else if (acc_addr == PORT_SECNUM) begin
          if (prog_mode) speed_q  <= acc_data;
          else           secnum_q <= acc_data;
        end
      end
      dev0_q <= seccnt_q[FORCE_BIT] ? SPD_MAX : speed_q[D0_LO +: SPD_W];
      dev1_q <= seccnt_q[FORCE_BIT] ? SPD_MAX : speed_q[SPD_W-1:0];
      slow_q <= speed_q[SLOW_BIT];
    end
  end

  AST_BIT3_READS_ONE: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_addr == PORT_SECCNT) |=> rdata_q[3]); // R8
  AST_BIT7_CLEARED: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seccnt_q[DATA_W-1]); // R3
  AST_SPEED_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_addr == PORT_SECNUM && !prog_mode) |=> $stable(speed_q)); // R7
  AST_RESET_SPEED_EVEN: assert property (@(posedge clk)
    rst |=> (speed_q[0] == 1'b0 && speed_q[DATA_W-1:SPD_W] == '0)); // R10
  AST_FORCE_MAX: assert property (@(posedge clk) disable iff (rst)
    (seccnt_q[FORCE_BIT] && !rst) |=> (dev0_q == SPD_MAX && dev1_q == SPD_MAX)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/ide_unlock_ctrl.sv
module ide_unlock_ctrl
  import ide_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [SPD_W-1:0]  jumper,
  output logic [DATA_W-1:0] io_rdata,
  output logic              prog_mode,
  output logic [DATA_W-1:0] speed_cfg,
  output logic [SPD_W-1:0]  dev0_speed,
  output logic [SPD_W-1:0]  dev1_speed,
  output logic              slow_bus
);
  logic acc_rd, acc_wr, seq_done;

  io_access_sampler u_sampler (
    .clk    (clk),
    .rst    (rst),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .acc_rd (acc_rd),
    .acc_wr (acc_wr)
  );

  unlock_seq_fsm u_seq (
    .clk       (clk),
    .rst       (rst),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_addr  (io_addr),
    .acc_d7    (io_wdata[DATA_W-1]),
    .prog_mode (prog_mode),
    .seq_done  (seq_done)
  );

  timing_cfg_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_addr  (io_addr),
    .acc_data  (io_wdata),
    .prog_mode (prog_mode),
    .seq_done  (seq_done),
    .jumper    (jumper),
    .rdata_q   (io_rdata),
    .speed_q   (speed_cfg),
    .dev0_q    (dev0_speed),
    .dev1_q    (dev1_speed),
    .slow_q    (slow_bus)
  );
endmodule

// File: tb/tb_ide_unlock_ctrl.sv
module tb_ide_unlock_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] io_addr = '0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [2:0] jumper = 3'b111;
  logic [7:0] io_rdata, speed_cfg;
  logic       prog_mode, slow_bus;
  logic [2:0] dev0_speed, dev1_speed;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // model state
  logic [7:0] m_sc, m_sn, m_spd, m_rd;
  bit         m_prog;
  int         m_step;

  always #10 clk = ~clk;

  ide_unlock_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_match(int step, bit wr, logic [9:0] a, logic [7:0] d);
    case (step)
      0:       return wr && a == 10'h1F2 && d[7];
      1:       return !wr && a == 10'h1F5;
      2, 5, 6: return !wr && a == 10'h1F2;
      3, 4:    return !wr && a == 10'h3F6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] m_read(logic [9:0] a);
    if (a == 10'h1F2) return m_sc | 8'h08;
    if (a == 10'h1F3) return m_prog ? m_spd : m_sn;
    return 8'h00;
  endfunction

  task automatic check_outputs(string tag);
    chk({tag, " R2/R5 prog_mode"}, prog_mode, m_prog);
    chk({tag, " R6 speed_cfg"}, speed_cfg, m_spd);
    chk({tag, " R11 rdata hold"}, io_rdata, m_rd);
    chk({tag, " R9/R12 dev0"}, dev0_speed, m_sc[6] ? 3'd7 : m_spd[5:3]);
    chk({tag, " R9/R12 dev1"}, dev1_speed, m_sc[6] ? 3'd7 : m_spd[2:0]);
    chk({tag, " R12 slow_bus"}, slow_bus, m_spd[6]);
  endtask

  task automatic access(bit wr, logic [9:0] a, logic [7:0] d, int hold = 1);
    bit pre_prog;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_rd = !wr; io_wr = wr;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk);
    io_rd = 0; io_wr = 0;
    pre_prog = m_prog;
    if (!wr) m_rd = m_read(a);
    if (m_match(m_step, wr, a, d)) begin
      if (m_step == 6) begin m_prog = 1; m_sc[7] = 0; m_step = 0; end
      else m_step++;
    end else m_step = (wr && a == 10'h1F2 && d[7]) ? 1 : 0;
    if (!wr && a == 10'h1F5) m_prog = 0;
    if (wr && a == 10'h1F2) m_sc = d;
    if (wr && a == 10'h1F3) begin
      if (pre_prog) m_spd = d; else m_sn = d;
    end
    @(negedge clk);
    check_outputs("access");
  endtask

  task automatic do_reset(logic [2:0] j);
    @(negedge clk);
    rst = 1; jumper = j;
    repeat (3) @(negedge clk);
    rst = 0;
    m_sc = 0; m_sn = 0; m_spd = {5'b0, j[2:1], 1'b0}; m_rd = 0; m_prog = 0; m_step = 0;
    chk("R10 reset prog_mode", prog_mode, 0);
    chk("R10 reset rdata", io_rdata, 0);
    chk("R10 reset speed from jumper", speed_cfg, m_spd);
    @(negedge clk);
    chk("R10 reset dev1 code", dev1_speed, {j[2:1], 1'b0});
    access(0, 10'h1F2, 0);
    chk("R10 R8 reset seccnt reads 0x08", io_rdata, 8'h08);
  endtask

  task automatic unlock_seq(logic [7:0] d, int hold3f6 = 1);
    access(1, 10'h1F2, d | 8'h80);
    access(0, 10'h1F5, 0);
    access(0, 10'h1F2, 0);
    access(0, 10'h3F6, 0, hold3f6);
    access(0, 10'h3F6, 0);
    access(0, 10'h1F2, 0);
    access(0, 10'h1F2, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset(3'b111);

    // R2 R3: exact order
    unlock_seq(8'h05);
    chk("R3 completing read keeps bit7", io_rdata[7], 1);
    chk("R2 mode open", prog_mode, 1);
    access(0, 10'h1F2, 0);
    chk("R3 bit7 cleared after unlock", io_rdata, 8'h0D);

    // R6 speed register
    access(1, 10'h1F3, 8'h6B);
    access(0, 10'h1F3, 0);
    chk("R6 speed readback", io_rdata, 8'h6B);
    chk("R6 dev0 field", dev0_speed, 3'd5);
    chk("R6 dev1 field", dev1_speed, 3'd3);

    // R9 force max
    access(1, 10'h1F2, 8'h40);
    chk("R9 forced dev0", dev0_speed, 3'd7);
    chk("R9 forced dev1", dev1_speed, 3'd7);
    access(1, 10'h1F2, 8'h00);

    // R5 close, R7 normal register
    access(0, 10'h1F5, 0);
    chk("R5 closed", prog_mode, 0);
    access(1, 10'h1F3, 8'h11);
    access(0, 10'h1F3, 0);
    chk("R7 sector number readback", io_rdata, 8'h11);
    chk("R7 speed untouched", speed_cfg, 8'h6B);
    access(0, 10'h1F7, 0);
    chk("R11 unowned port reads zero", io_rdata, 8'h00);

    // R4 broken order
    access(1, 10'h1F2, 8'h80);
    access(0, 10'h1F5, 0);
    access(0, 10'h1F2, 0);
    access(0, 10'h1F7, 0);
    access(0, 10'h3F6, 0);
    access(0, 10'h3F6, 0);
    access(0, 10'h1F2, 0);
    access(0, 10'h1F2, 0);
    chk("R4 broken order stays closed", prog_mode, 0);
    chk("R3 bit7 kept when unmatched", io_rdata[7], 1);

    // R4 restart mid-sequence
    access(1, 10'h1F2, 8'h80);
    access(0, 10'h1F5, 0);
    unlock_seq(8'h01);
    chk("R4 restart then unlock", prog_mode, 1);

    // R1 held strobe
    access(0, 10'h1F5, 0);
    unlock_seq(8'h00, 3);
    chk("R1 held strobe counts once", prog_mode, 1);

    // R10 other jumper
    do_reset(3'b011);
    chk("R10 jumper 3 loads 2", speed_cfg, 8'h02);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 19);
      if (k == 0) unlock_seq(8'($urandom));
      else begin
        logic [9:0] a;
        case ($urandom_range(0, 5))
          0: a = 10'h1F2; 1: a = 10'h1F3; 2: a = 10'h1F5;
          3: a = 10'h3F6; 4: a = 10'h1F0; default: a = 10'h1F7;
        endcase
        access($urandom_range(0, 2) == 0, a, 8'($urandom), $urandom_range(1, 2));
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule